// File: doc/BRIEF.md
# Sector Protection and Lock Controller

This block keeps the write protection state of a 512 KB non-volatile array that is divided into eleven sectors of unequal size. Each sector has one protection flag. A command decoder sends it single-sector protect and unprotect requests and status-register writes. A status write can change a lock flag, and it can also protect or unprotect every sector at once. A write-protect input works together with the lock flag to freeze the whole protection state.

The program and erase sequencers ask the block two questions, and both answers are combinational. The first is whether a given byte address is protected. The second is whether an aligned erase region of 4 KB, 32 KB, 64 KB or the whole array overlaps any protected sector. A 32 KB or 64 KB region in the upper part of the map spans several small sectors, and the region is refused if any one of those sectors is protected. The lock flag is brought out so that the status register can show it.

Top module: `spl_ctrl`

## Requirements
- R1: After reset every sector reads as protected and the lock flag reads 0.
- R2: The sector map is fixed. Sectors 0 to 6 are 64 KB each, starting at 00000h. Sector 7 covers 70000h–77FFFh, sector 8 covers 78000h–79FFFh, sector 9 covers 7A000h–7BFFFh and sector 10 covers 7C000h–7FFFFh.
- R3: A request with op code 1 (protect) marks the sector that contains the request address as protected from the next clock edge on, if the lock flag is 0.
- R4: A request with op code 2 (unprotect) marks the sector that contains the request address as unprotected from the next clock edge on, if the lock flag is 0.
- R5: While the lock flag is 1, protect and unprotect requests change nothing.
- R6: A request with op code 3 (status write) loads data bit 7 into the lock flag. For example, 0Fh clears the flag and F0h sets it. This happens unless the hardware lock of R8 is active.
- R7: On a status write issued while the lock flag is still 0, data bits 5:2 equal to 0000 unprotect every sector and 1111 protect every sector. Any other value of those bits leaves the sector flags as they were.
- R8: While the write-protect input is 1 and the lock flag is 1, a status write changes neither the lock flag nor any sector flag.
- R9: The query output shows, in the same cycle, whether the sector that contains the query address is protected.
- R10: The erase region is the erase address aligned down to the chosen size. Size code 0 is 4 KB, 1 is 32 KB, 2 is 64 KB and 3 is the whole array. The erase-blocked output is 1 exactly when that region overlaps at least one protected sector.
- R11: A cycle without a request, or a request with op code 0, changes neither the lock flag nor any sector flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wp_i | input | 1 | Write-protect input, 1 = asserted |
| req_valid_i | input | 1 | Request strobe, acted on at the clock edge |
| req_op_i | input | 2 | 0 none, 1 protect, 2 unprotect, 3 status write |
| req_addr_i | input | 19 | Byte address that selects the target sector |
| req_data_i | input | 8 | Status write data |
| qry_addr_i | input | 19 | Byte address to test |
| qry_prot_o | output | 1 | Sector of the query address is protected |
| ers_addr_i | input | 19 | Erase address |
| ers_size_i | input | 2 | Erase size code |
| ers_blocked_o | output | 1 | Erase region overlaps a protected sector |
| lock_o | output | 1 | Lock flag |

## Verification
If a sector flag is wrong, the effect shows only when a query or an erase region falls on that sector. For this reason every sector is probed at both its first and its last address after each request, starting with the first cycle that follows the edge which applied the request. A region decoder with a wrong boundary shows up in these same probes, and also in multi-sector erase checks that cover the small upper sectors. A lock flag that is wrong becomes visible one cycle after the status write, both at lock_o and in the sector flags of the next protect or unprotect request, which are changed when they should be frozen or frozen when they should change.

// File: rtl/spl_pkg.sv
package spl_pkg;

   typedef enum logic [1:0] {
      OP_NONE      = 2'd0,
      OP_PROTECT   = 2'd1,
      OP_UNPROTECT = 2'd2,
      OP_WRSTAT    = 2'd3
   } spl_op_e;

   typedef enum logic [1:0] {
      ER_4K  = 2'd0,
      ER_32K = 2'd1,
      ER_64K = 2'd2,
      ER_ALL = 2'd3
   } spl_erase_e;

   localparam int unsigned MAP_W       = 20;
   localparam int unsigned MAP_SECTORS = 11;
   localparam int unsigned UNIFORM_CNT = 7;
   localparam int unsigned UNIFORM_SZ  = 32'h1_0000;
   localparam int unsigned TAIL_CNT    = 4;

   localparam int unsigned LOCK_BIT = 7;
   localparam int unsigned GLB_HI   = 5;
   localparam int unsigned GLB_LO   = 2;

   function automatic int unsigned tail_sz(input int unsigned k);
      case (k)
         0:       return 32'h8000;
         1:       return 32'h2000;
         2:       return 32'h2000;
         default: return 32'h4000;
      endcase
   endfunction

   // start address of sector idx; idx == MAP_SECTORS yields the array end
   function automatic logic [MAP_W-1:0] sec_lo(input int unsigned idx);
      int unsigned base;
      if (idx < UNIFORM_CNT) begin
         base = idx * UNIFORM_SZ;
      end else begin
         base = UNIFORM_CNT * UNIFORM_SZ;
         for (int unsigned k = 0; k < TAIL_CNT; k++)
            if (idx > UNIFORM_CNT + k) base += tail_sz(k);
      end
      return MAP_W'(base);
   endfunction

endpackage

// File: rtl/spl_range_match.sv
module spl_range_match
   import spl_pkg::*;
#(
   parameter int unsigned ADDR_W  = 19,
   parameter int unsigned NUM_SEC = 11
) (
   input  logic [ADDR_W:0]      lo_i,
   input  logic [ADDR_W:0]      hi_i,
   output logic [NUM_SEC-1:0]   hit_o
);
   for (genvar i = 0; i < NUM_SEC; i++) begin : g_sec
      localparam logic [ADDR_W:0] SEC_FIRST = (ADDR_W+1)'(sec_lo(i));
      localparam logic [ADDR_W:0] SEC_LAST  = (ADDR_W+1)'(sec_lo(i + 1)) - 1'b1;
      assign hit_o[i] = (lo_i <= SEC_LAST) && (hi_i >= SEC_FIRST);
   end
endmodule

// File: rtl/spl_erase_span.sv
module spl_erase_span
   import spl_pkg::*;
#(
   parameter int unsigned ADDR_W   = 19,
   parameter int unsigned NUM_SEC  = 11,
   parameter int unsigned SMALL_LG = 12,
   parameter int unsigned MID_LG   = 15,
   parameter int unsigned BIG_LG   = 16
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [1:0]        size_i,
   output logic [ADDR_W:0]   lo_o,
   output logic [ADDR_W:0]   hi_o
);
   localparam logic [ADDR_W:0] END_ADDR   = (ADDR_W+1)'(sec_lo(NUM_SEC));
   localparam logic [ADDR_W:0] SMALL_MASK = (ADDR_W+1)'((32'd1 << SMALL_LG) - 32'd1);
   localparam logic [ADDR_W:0] MID_MASK   = (ADDR_W+1)'((32'd1 << MID_LG) - 32'd1);
   localparam logic [ADDR_W:0] BIG_MASK   = (ADDR_W+1)'((32'd1 << BIG_LG) - 32'd1);

   logic [ADDR_W:0] mask;
   logic [ADDR_W:0] base;

   always_comb begin
      unique case (spl_erase_e'(size_i))
         ER_4K:   mask = SMALL_MASK;
         ER_32K:  mask = MID_MASK;
         ER_64K:  mask = BIG_MASK;
         default: mask = '0;
      endcase
      base = {1'b0, addr_i} & ~mask;
      if (spl_erase_e'(size_i) == ER_ALL) begin
         lo_o = '0;
         hi_o = END_ADDR - 1'b1;
      end else begin
         lo_o = base;
         hi_o = base | mask;
      end
   end
endmodule

// File: rtl/spl_prot_regs.sv
module spl_prot_regs
   import spl_pkg::*;
#(
   parameter int unsigned NUM_SEC = 11
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wp_i,
   input  logic               req_valid_i,
   input  logic [1:0]         req_op_i,
   input  logic [NUM_SEC-1:0] sel_i,
   input  logic               new_lock_i,
   input  logic [3:0]         glb_code_i,
   output logic [NUM_SEC-1:0] prot_o,
   output logic               lock_o
);
   logic [NUM_SEC-1:0] prot_q;
   logic               lock_q;
   logic               hw_locked;

   assign hw_locked = wp_i & lock_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prot_q <= '1;
         lock_q <= 1'b0;
      end else if (req_valid_i) begin
         unique case (spl_op_e'(req_op_i))
            OP_PROTECT: begin
               if (!lock_q) prot_q <= prot_q | sel_i;
            end
            OP_UNPROTECT: begin
               if (!lock_q) prot_q <= prot_q & ~sel_i;
            end
            OP_WRSTAT: begin
               if (!hw_locked) begin
                  lock_q <= new_lock_i;
                  if (!lock_q) begin
                     if (glb_code_i == 4'b0000)      prot_q <= '0;
                     else if (glb_code_i == 4'b1111) prot_q <= '1;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   assign prot_o = prot_q;
   assign lock_o = lock_q;
endmodule

// File: rtl/spl_ctrl.sv
module spl_ctrl
   import spl_pkg::*;
#(
   parameter int unsigned ADDR_W   = 19,
   parameter int unsigned NUM_SEC  = 11,
   parameter int unsigned SMALL_LG = 12,
   parameter int unsigned MID_LG   = 15,
   parameter int unsigned BIG_LG   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wp_i,
   input  logic              req_valid_i,
   input  logic [1:0]        req_op_i,
   input  logic [ADDR_W-1:0] req_addr_i,
   input  logic [7:0]        req_data_i,
   input  logic [ADDR_W-1:0] qry_addr_i,
   output logic              qry_prot_o,
   input  logic [ADDR_W-1:0] ers_addr_i,
   input  logic [1:0]        ers_size_i,
   output logic              ers_blocked_o,
   output logic              lock_o
);
   if (NUM_SEC != MAP_SECTORS) begin : g_bad_count
      $error("spl_ctrl: NUM_SEC must match the fixed sector map");
   end
   if (ADDR_W + 1 < MAP_W) begin : g_bad_width
      $error("spl_ctrl: ADDR_W too narrow for the sector map");
   end
   if (!(SMALL_LG < MID_LG && MID_LG < BIG_LG && BIG_LG < ADDR_W)) begin : g_bad_sizes
      $error("spl_ctrl: erase sizes must grow and fit in the array");
   end

   logic [NUM_SEC-1:0] prot_q;
   logic [NUM_SEC-1:0] req_hit;
   logic [NUM_SEC-1:0] qry_hit;
   logic [NUM_SEC-1:0] ers_hit;
   logic [ADDR_W:0]    ers_lo;
   logic [ADDR_W:0]    ers_hi;
   logic               unused_data;

   assign unused_data = ^{req_data_i[6], req_data_i[1:0]};

   spl_range_match #(.ADDR_W(ADDR_W), .NUM_SEC(NUM_SEC)) u_req_dec (
      .lo_i ({1'b0, req_addr_i}),
      .hi_i ({1'b0, req_addr_i}),
      .hit_o(req_hit)
   );

   spl_range_match #(.ADDR_W(ADDR_W), .NUM_SEC(NUM_SEC)) u_qry_dec (
      .lo_i ({1'b0, qry_addr_i}),
      .hi_i ({1'b0, qry_addr_i}),
      .hit_o(qry_hit)
   );

   spl_erase_span #(
      .ADDR_W(ADDR_W), .NUM_SEC(NUM_SEC),
      .SMALL_LG(SMALL_LG), .MID_LG(MID_LG), .BIG_LG(BIG_LG)
   ) u_span (
      .addr_i(ers_addr_i),
      .size_i(ers_size_i),
      .lo_o  (ers_lo),
      .hi_o  (ers_hi)
   );

   spl_range_match #(.ADDR_W(ADDR_W), .NUM_SEC(NUM_SEC)) u_ers_dec (
      .lo_i (ers_lo),
      .hi_i (ers_hi),
      .hit_o(ers_hit)
   );

   spl_prot_regs #(.NUM_SEC(NUM_SEC)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wp_i       (wp_i),
      .req_valid_i(req_valid_i),
      .req_op_i   (req_op_i),
      .sel_i      (req_hit),
      .new_lock_i (req_data_i[LOCK_BIT]),
      .glb_code_i (req_data_i[GLB_HI:GLB_LO]),
      .prot_o     (prot_q),
      .lock_o     (lock_o)
   );

   assign qry_prot_o    = |(qry_hit & prot_q);
   assign ers_blocked_o = |(ers_hit & prot_q);
endmodule

// File: rtl/spl_ctrl_chk.sv
module spl_ctrl_chk #(
   parameter int unsigned ADDR_W   = 19,
   parameter int unsigned NUM_SEC  = 11,
   parameter int unsigned SMALL_LG = 12
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       wp_i,
   input logic                       req_valid_i,
   input logic [1:0]                 req_op_i,
   input logic [ADDR_W-1:SMALL_LG]   qry_blk_i,
   input logic                       qry_prot_o,
   input logic [ADDR_W-1:SMALL_LG]   ers_blk_i,
   input logic [1:0]                 ers_size_i,
   input logic                       ers_blocked_o,
   input logic                       lock_o,
   input logic [NUM_SEC-1:0]         prot_q
);
   p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> ((&prot_q) && !lock_o));

   p_sw_lock_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
      lock_o |=> $stable(prot_q));

   p_lock_only_by_wrstat_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid_i && req_op_i == 2'd3) |=> $stable(lock_o));

   p_hw_lock_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wp_i && lock_o) |=> (lock_o && $stable(prot_q)));

   p_erase_sees_query_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (qry_prot_o && qry_blk_i == ers_blk_i) |-> ers_blocked_o);

   p_chip_erase_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ers_size_i == 2'd3) |-> (ers_blocked_o == (prot_q != '0)));

   p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_valid_i || req_op_i == 2'd0) |=> ($stable(prot_q) && $stable(lock_o)));
endmodule

bind spl_ctrl spl_ctrl_chk #(
   .ADDR_W(ADDR_W), .NUM_SEC(NUM_SEC), .SMALL_LG(SMALL_LG)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .wp_i         (wp_i),
   .req_valid_i  (req_valid_i),
   .req_op_i     (req_op_i),
   .qry_blk_i    (qry_addr_i[ADDR_W-1:SMALL_LG]),
   .qry_prot_o   (qry_prot_o),
   .ers_blk_i    (ers_addr_i[ADDR_W-1:SMALL_LG]),
   .ers_size_i   (ers_size_i),
   .ers_blocked_o(ers_blocked_o),
   .lock_o       (lock_o),
   .prot_q       (prot_q)
);

// File: tb/spl_ctrl_bench.sv
module spl_ctrl_bench;
   localparam int AW = 19;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wp = 1'b0;
   logic          req_valid = 1'b0;
   logic [1:0]    req_op = 2'd0;
   logic [AW-1:0] req_addr = '0;
   logic [7:0]    req_data = 8'h00;
   logic [AW-1:0] qry_addr = '0;
   logic          qry_prot;
   logic [AW-1:0] ers_addr = '0;
   logic [1:0]    ers_size = 2'd0;
   logic          ers_blocked;
   logic          lock_o;

   spl_ctrl u_spl_ctrl (
      .clk(clk), .rst_n(rst_n), .wp_i(wp),
      .req_valid_i(req_valid), .req_op_i(req_op), .req_addr_i(req_addr), .req_data_i(req_data),
      .qry_addr_i(qry_addr), .qry_prot_o(qry_prot),
      .ers_addr_i(ers_addr), .ers_size_i(ers_size), .ers_blocked_o(ers_blocked),
      .lock_o(lock_o)
   );

   always #5 clk = ~clk;

   typedef struct {
      int    kind;   // 0 query, 1 erase, 2 lock
      int    addr;
      int    size;
      logic  exp;
      string tag;
   } item_t;

   item_t sb[$];
   int    compared = 0;
   int    mismatched = 0;
   bit    done = 0;

   logic [10:0] m_prot;
   logic        m_lock;

   function automatic int tb_sec(input int a);
      if (a < 'h70000) return a / 'h10000;
      if (a < 'h78000) return 7;
      if (a < 'h7A000) return 8;
      if (a < 'h7C000) return 9;
      return 10;
   endfunction

   function automatic int tb_base(input int i);
      case (i)
         7:  return 'h70000;
         8:  return 'h78000;
         9:  return 'h7A000;
         10: return 'h7C000;
         11: return 'h80000;
         default: return i * 'h10000;
      endcase
   endfunction

   function automatic logic tb_ers(input int a, input int sz);
      int span;
      int lo;
      case (sz)
         0: span = 'h1000;
         1: span = 'h8000;
         2: span = 'h10000;
         default: span = 'h80000;
      endcase
      lo = a & ~(span - 1);
      for (int b = lo; b < lo + span; b += 'h1000)
         if (m_prot[tb_sec(b)]) return 1'b1;
      return 1'b0;
   endfunction

   // monitor: compare each queued expectation away from the clock edge
   always @(negedge clk) begin
      #2;
      while (sb.size() > 0) begin
         item_t it;
         logic  act;
         it = sb.pop_front();
         case (it.kind)
            0: act = qry_prot;
            1: act = ers_blocked;
            default: act = lock_o;
         endcase
         compared++;
         if (act !== it.exp) begin
            mismatched++;
            $display("FAIL %s kind=%0d addr=%h size=%0d actual=%b expected=%b",
                     it.tag, it.kind, it.addr, it.size, act, it.exp);
         end
      end
   end

   task automatic probe(input int kind, input int a, input int sz, input logic e, input string tag);
      item_t it;
      @(negedge clk);
      if (kind == 0) qry_addr = a[AW-1:0];
      if (kind == 1) begin ers_addr = a[AW-1:0]; ers_size = sz[1:0]; end
      it.kind = kind; it.addr = a; it.size = sz; it.exp = e; it.tag = tag;
      sb.push_back(it);
   endtask

   task automatic check_all(input string tag);
      for (int i = 0; i < 11; i++) begin
         probe(0, tb_base(i), 0, m_prot[i], {tag, " R2 R9 first"});
         probe(0, tb_base(i + 1) - 1, 0, m_prot[i], {tag, " R2 R9 last"});
      end
      probe(2, 0, 0, m_lock, {tag, " lock"});
   endtask

   task automatic ers(input int a, input int sz, input string tag);
      probe(1, a, sz, tb_ers(a, sz), tag);
   endtask

   task automatic do_req(input logic [1:0] op, input int a, input logic [7:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_op = op; req_addr = a[AW-1:0]; req_data = d;
      case (op)
         2'd1: if (!m_lock) m_prot[tb_sec(a)] = 1'b1;
         2'd2: if (!m_lock) m_prot[tb_sec(a)] = 1'b0;
         2'd3: if (!(wp && m_lock)) begin
            if (!m_lock) begin
               if (d[5:2] == 4'b0000) m_prot = '0;
               else if (d[5:2] == 4'b1111) m_prot = '1;
            end
            m_lock = d[7];
         end
         default: ;
      endcase
      @(posedge clk);
      #1 req_valid = 1'b0;
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         mismatched++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      m_prot = '1;
      m_lock = 1'b0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      check_all("R1 reset");

      // R4 single sector unprotect, small sectors and boundaries
      do_req(2'd2, 'h78123, 8'h00);
      check_all("R4 unprot s8");
      do_req(2'd2, 'h7BFFF, 8'h00);
      do_req(2'd2, 'h7C000, 8'h00);
      do_req(2'd2, 'h00005, 8'h00);
      check_all("R4 unprot s9 s10 s0");
      do_req(2'd1, 'h7A800, 8'h00);
      check_all("R3 prot s9");

      // R10 erase regions
      ers('h78000, 0, "R10 4K in s8");
      ers('h70000, 2, "R10 64K over s7..s10");
      ers('h7C000, 1, "R10 32K over s8..s10");
      ers('h7C800, 0, "R10 4K in s10");
      ers('h0F000, 2, "R10 64K s0");
      ers('h12345, 3, "R10 whole array");

      // R7 non-global pattern, then global unprotect
      do_req(2'd3, 0, 8'h0F);
      check_all("R7 0Fh no global");
      do_req(2'd3, 0, 8'h40);
      check_all("R7 global unprotect");
      ers('h00000, 3, "R10 whole array clear");

      // R6 set lock, R5 ignore single-sector ops
      do_req(2'd3, 0, 8'hF0);
      check_all("R6 F0h sets lock");
      do_req(2'd1, 'h30000, 8'h00);
      check_all("R5 protect ignored");
      do_req(2'd3, 0, 8'h3C);
      check_all("R6 R7 unlock, global ignored");
      do_req(2'd3, 0, 8'hBC);
      check_all("R7 global protect and lock");

      // R8 hardware lock
      wp = 1'b1;
      do_req(2'd3, 0, 8'h00);
      check_all("R8 wrstat frozen");
      do_req(2'd2, 'h50000, 8'h00);
      check_all("R8 unprot frozen");
      wp = 1'b0;
      do_req(2'd3, 0, 8'h0F);
      check_all("R6 unlock after wp released");

      // R11 no-op request
      do_req(2'd0, 'h50000, 8'h00);
      check_all("R11 op0 no change");
      do_req(2'd2, 'h5FFFF, 8'h00);
      check_all("R4 unprot s5");
      ers('h58000, 1, "R10 32K in s5");
      ers('h60000, 1, "R10 32K in s6");

      repeat (3) @(posedge clk);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule